// File: doc/BRIEF.md
# Exception state register unit

This unit keeps the exception state of a small 32-bit RISC core. It holds four registers: the exception return address, the cause word, the faulting data address and the status word. When the core's control sequencer reports an exception it pulses a strobe together with a four-bit reason code, the current program counter and, for address errors, the bad address. The unit saves the return address, records the reason and pushes the mode/enable stack so that the core runs in kernel mode with interrupts off. The core then fetches from the fixed handler entry address that the unit drives. A return-from-exception pulse pops the stack again.

Five hardware interrupt lines are sampled every cycle. Each one sets a pending flag in the cause word, and the flag stays set until software clears it, whatever the enable state is at the time. The unit raises an interrupt request when the current enable bit is set and any pending flag meets a set mask bit. Software reads the registers by number through a combinational read port. It can write the status word and acknowledge pending flags through a single-cycle write port.

The status word is updated by one of four actions, chosen each cycle in priority order: STK_PUSH (an exception), STK_POP (a return), STK_LOAD (a software write to the status word) and STK_HOLD (none of these). The transitions are exclusive and the order is fixed, so an exception beats a return, and a return beats a write.

Top module: `exc_state_unit`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 all read 0 and irq_req is 0.
- R2: entry_addr is always 32'h8000_0080.
- R3: On an exception, status bits 5:0 become {old bits 3:0, 2'b00}, which gives kernel mode (bit 1 = 0) with interrupts disabled (bit 0 = 0). Status bits 15:8 are unchanged. Each stack pair is {k, e}: k = 1 means user mode, e = 1 means enabled. The current pair is bits 1:0, the previous pair bits 3:2, the old pair bits 5:4.
- R4: On a return without an exception, status bits 3:0 take the old bits 5:2 and bits 5:4 keep their value. If an exception and a return arrive in the same cycle, the exception wins and the return is dropped.
- R5: On an exception, cause bits 5:2 take exc_code. Between exceptions the code field holds its value.
- R6: A high on hw_irq[i] sets the pending flag at cause bit 11+i on the next edge. The flag is set regardless of the enable and mask bits. It stays set until a write to register 13 carries a 1 at that bit position. If a line is high in the same cycle as its clear, the new arrival wins.
- R7: irq_req is high exactly when status bit 0 is 1 and some pending flag at cause bit 11+i has its mask bit at status bit 11+i set.
- R8: On an exception, register 14 takes pc_cur - 4 when pc_incr is 1, and pc_cur otherwise.
- R9: Register 8 loads fault_addr only on exceptions with code 4 (load/fetch address error) or code 5 (store address error). On every other cycle it holds its value.
- R10: Reading number 8 returns the faulting address, 12 the status word, 13 the cause word and 14 the return address. Any other number returns 0. Status bits 7:6 and 31:16, and cause bits 31:16, 10:6 and 1:0, always read 0.
- R11: A write to number 12 loads status bits 15:8 and 5:0 from wr_data. It is lost if an exception or a return occurs in the same cycle. Writes to numbers 8 and 14 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception strobe, one cycle per exception |
| exc_code | input | 4 | Reason code for the exception |
| pc_cur | input | 32 | Program counter of the core |
| pc_incr | input | 1 | pc_cur has already been advanced by 4 |
| fault_addr | input | 32 | Address that caused an address error |
| hw_irq | input | 5 | Hardware interrupt lines |
| eret | input | 1 | Return-from-exception pulse |
| wr_en | input | 1 | Register write strobe |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data, combinational from rd_num |
| entry_addr | output | 32 | Handler entry address |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Nested exceptions followed by two returns show whether the three-deep stack shifts the right way in each direction, rather than only clearing the enable bit. Interrupts that arrive while interrupts are disabled, or in the same cycle as their clear, separate sticky latching from level following and show which of set and clear has priority. Exceptions carrying address-error codes are mixed with others carrying unrelated codes, together with same-cycle exception/return and exception/write pairs, to expose a wrongly qualified load or a wrong priority. A long run of random traffic, compared each cycle against a behavioural model, covers combinations that the directed cases miss.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam logic [31:0] ENTRY_ADDR = 32'h8000_0080;
    localparam int          CODE_LO    = 2;
    localparam int          CODE_W     = 4;
    localparam logic [3:0]  CODE_ADDR_LD = 4'd4;
    localparam logic [3:0]  CODE_ADDR_ST = 4'd5;
    localparam logic [15:0] STATUS_WMASK = 16'hFF3F;

    typedef enum logic [4:0] {
        RN_BADADDR = 5'd8,
        RN_STATUS  = 5'd12,
        RN_CAUSE   = 5'd13,
        RN_EPC     = 5'd14
    } regnum_e;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_LOAD
    } stk_op_e;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_valid,
    input  logic        eret,
    input  logic        wr_load,
    input  logic [15:0] wr_data,
    output logic [15:0] status_q
);
    stk_op_e op;

    always_comb begin
        if (exc_valid)    op = STK_PUSH;
        else if (eret)    op = STK_POP;
        else if (wr_load) op = STK_LOAD;
        else              op = STK_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            unique case (op)
                STK_PUSH: status_q[5:0] <= {status_q[3:0], 2'b00};
                STK_POP:  status_q[3:0] <= status_q[5:2];
                STK_LOAD: status_q      <= wr_data & STATUS_WMASK;
                STK_HOLD: status_q      <= status_q;
            endcase
        end
    end

    assert_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
                      && (status_q[15:8] == $past(status_q[15:8])));

    assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_valid) |=> (status_q[3:0] == $past(status_q[5:2]))
                                 && (status_q[5:4] == $past(status_q[5:4])));

    assert_kernel_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (status_q[1:0] == 2'b00));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_pkg::*;
#(
    parameter int NHW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [NHW-1:0]    hw_irq,
    input  logic              clr_en,
    input  logic [NHW-1:0]    clr_bits,
    output logic [NHW-1:0]    pend_q,
    output logic [CODE_W-1:0] code_q
);
    logic [NHW-1:0] pend_d;

    for (genvar i = 0; i < NHW; i++) begin : g_pend
        assign pend_d[i] = hw_irq[i] | (pend_q[i] & ~(clr_en & clr_bits[i]));

        assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !(clr_en && clr_bits[i])) |=> pend_q[i]);

        assert_pend_arrive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hw_irq[i] |=> pend_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            code_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (exc_valid) code_q <= exc_code;
        end
    end

    assert_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (code_q == $past(exc_code)));

    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> $stable(code_q));
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   pc_cur,
    input  logic              pc_incr,
    input  logic [XLEN-1:0]   fault_addr,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   bad_q
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] epc_d;
    logic            bad_ld;

    assign epc_d  = pc_incr ? (pc_cur - INSN_BYTES) : pc_cur;
    assign bad_ld = exc_valid && ((exc_code == CODE_ADDR_LD) || (exc_code == CODE_ADDR_ST));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q <= '0;
            bad_q <= '0;
        end else begin
            if (exc_valid) epc_q <= epc_d;
            if (bad_ld)    bad_q <= fault_addr;
        end
    end

    assert_epc_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && pc_incr) |=> ((epc_q + INSN_BYTES) == $past(pc_cur)));

    assert_epc_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !pc_incr) |=> (epc_q == $past(pc_cur)));

    assert_bad_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid || ((exc_code != CODE_ADDR_LD) && (exc_code != CODE_ADDR_ST)))
        |=> $stable(bad_q));
endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NHW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_valid,
    input  logic [3:0]      exc_code,
    input  logic [XLEN-1:0] pc_cur,
    input  logic            pc_incr,
    input  logic [XLEN-1:0] fault_addr,
    input  logic [NHW-1:0]  hw_irq,
    input  logic            eret,
    input  logic            wr_en,
    input  logic [4:0]      wr_num,
    input  logic [XLEN-1:0] wr_data,
    input  logic [4:0]      rd_num,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] entry_addr,
    output logic            irq_req
);
    localparam int PEND_LO = 16 - NHW;

    logic [15:0]       status_q;
    logic [NHW-1:0]    pend_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   bad_q;
    logic              status_ld;
    logic              cause_clr;
    logic [XLEN-1:0]   status_word;
    logic [XLEN-1:0]   cause_word;
    logic              wr_hi_unused;

    assign wr_hi_unused = ^wr_data[XLEN-1:16];
    assign status_ld    = wr_en && (wr_num == RN_STATUS);
    assign cause_clr    = wr_en && (wr_num == RN_CAUSE);

    exc_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_valid(exc_valid),
        .eret     (eret),
        .wr_load  (status_ld),
        .wr_data  (wr_data[15:0]),
        .status_q (status_q)
    );

    exc_cause_reg #(.NHW(NHW)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_valid(exc_valid),
        .exc_code (exc_code),
        .hw_irq   (hw_irq),
        .clr_en   (cause_clr),
        .clr_bits (wr_data[15:PEND_LO]),
        .pend_q   (pend_q),
        .code_q   (code_q)
    );

    exc_addr_regs #(.XLEN(XLEN)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .pc_cur    (pc_cur),
        .pc_incr   (pc_incr),
        .fault_addr(fault_addr),
        .epc_q     (epc_q),
        .bad_q     (bad_q)
    );

    always_comb begin
        status_word        = '0;
        status_word[15:0]  = status_q;
        cause_word         = '0;
        cause_word[15:PEND_LO] = pend_q;
        cause_word[CODE_LO+CODE_W-1:CODE_LO] = code_q;
    end

    always_comb begin
        unique case (rd_num)
            RN_BADADDR: rd_data = bad_q;
            RN_STATUS:  rd_data = status_word;
            RN_CAUSE:   rd_data = cause_word;
            RN_EPC:     rd_data = epc_q;
            default:    rd_data = '0;
        endcase
    end

    assign entry_addr = XLEN'(ENTRY_ADDR);
    assign irq_req    = status_q[0] & (|(pend_q & status_q[15:PEND_LO]));

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && (|(hw_irq & status_q[15:PEND_LO])) && !exc_valid && !eret && !status_ld)
        |=> irq_req);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !irq_req);
endmodule

// File: tb/exc_state_unit_tb.sv
module exc_state_unit_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid;
    logic [3:0]  exc_code;
    logic [31:0] pc_cur;
    logic        pc_incr;
    logic [31:0] fault_addr;
    logic [4:0]  hw_irq;
    logic        eret;
    logic        wr_en;
    logic [4:0]  wr_num;
    logic [31:0] wr_data;
    logic [4:0]  rd_num;
    logic [31:0] rd_data;
    logic [31:0] entry_addr;
    logic        irq_req;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_status = 0, m_cause = 0, m_epc = 0, m_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    exc_state_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .pc_cur(pc_cur), .pc_incr(pc_incr), .fault_addr(fault_addr),
        .hw_irq(hw_irq), .eret(eret), .wr_en(wr_en), .wr_num(wr_num),
        .wr_data(wr_data), .rd_num(rd_num), .rd_data(rd_data),
        .entry_addr(entry_addr), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_idle();
        exc_valid = 0; exc_code = 0; pc_cur = 0; pc_incr = 0; fault_addr = 0;
        hw_irq = 0; eret = 0; wr_en = 0; wr_num = 0; wr_data = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] n);
        if (n == 5'd8)  return m_bad;
        if (n == 5'd12) return m_status;
        if (n == 5'd13) return m_cause;
        if (n == 5'd14) return m_epc;
        return 32'h0;
    endfunction

    function automatic logic model_irq();
        logic [4:0] p, m;
        p = m_cause[15:11];
        m = m_status[15:11];
        return m_status[0] && ((p & m) != 0);
    endfunction

    task automatic model_update();
        logic [31:0] ns, nc, ne, nb;
        logic [4:0]  pend;
        logic [3:0]  code;
        ns = m_status; ne = m_epc; nb = m_bad;
        if (exc_valid)
            ns[5:0] = {m_status[3:0], 2'b00};
        else if (eret)
            ns[3:0] = m_status[5:2];
        else if (wr_en && wr_num == 5'd12)
            ns = wr_data & 32'h0000_FF3F;
        pend = m_cause[15:11];
        if (wr_en && wr_num == 5'd13) pend = pend & ~wr_data[15:11];
        pend = pend | hw_irq;
        code = exc_valid ? exc_code : m_cause[5:2];
        nc = (32'(pend) << 11) | (32'(code) << 2);
        if (exc_valid) ne = pc_incr ? pc_cur - 32'd4 : pc_cur;
        if (exc_valid && (exc_code == 4'd4 || exc_code == 4'd5)) nb = fault_addr;
        m_status = ns; m_cause = nc; m_epc = ne; m_bad = nb;
    endtask

    // one clock with the inputs already driven; compare with the model afterwards
    task automatic tick(input logic [4:0] sel);
        rd_num = sel;
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R10 model read", rd_data, model_read(sel));
        chk("R7 model irq", {31'b0, irq_req}, {31'b0, model_irq()});
        set_idle();
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] n, input logic [31:0] exp);
        rd_num = n;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        set_idle();
        rd_num = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_chk("R1 badaddr", 5'd8, 0);
        rd_chk("R1 status", 5'd12, 0);
        rd_chk("R1 cause", 5'd13, 0);
        rd_chk("R1 epc", 5'd14, 0);
        chk("R1 irq", {31'b0, irq_req}, 0);
        chk("R2 entry", entry_addr, 32'h8000_0080);

        // R11 status write masks reserved bits
        @(negedge clk); wr_en = 1; wr_num = 12; wr_data = 32'hFFFF_FFFF; tick(12);
        rd_chk("R11 status write mask", 5'd12, 32'h0000_FF3F);
        @(negedge clk); wr_en = 1; wr_num = 12; wr_data = 32'h0000_F805; tick(12);
        rd_chk("R11 status load", 5'd12, 32'h0000_F805);

        // R6/R7 interrupt latch and request
        @(negedge clk); hw_irq = 5'b00100; tick(13);
        rd_chk("R6 pending set", 5'd13, 32'h0000_2000);
        chk("R7 irq raised", {31'b0, irq_req}, 1);

        // R3/R5/R8 exception with incremented pc
        @(negedge clk); exc_valid = 1; exc_code = 0; pc_cur = 32'h100; pc_incr = 1; tick(12);
        rd_chk("R3 push", 5'd12, 32'h0000_F814);
        rd_chk("R8 epc minus 4", 5'd14, 32'h0000_00FC);
        rd_chk("R5 code 0", 5'd13, 32'h0000_2000);
        chk("R7 irq off in kernel", {31'b0, irq_req}, 0);

        // R6 clear and new arrival while disabled
        @(negedge clk); wr_en = 1; wr_num = 13; wr_data = 32'h2000; hw_irq = 5'b00001; tick(13);
        rd_chk("R6 clear and latch disabled", 5'd13, 32'h0000_0800);
        chk("R7 irq masked by enable", {31'b0, irq_req}, 0);

        // R9 address error load
        @(negedge clk); exc_valid = 1; exc_code = 4; pc_cur = 32'h200; fault_addr = 32'hDEAD_BEE0; tick(8);
        rd_chk("R9 badaddr load", 5'd8, 32'hDEAD_BEE0);
        rd_chk("R8 epc as is", 5'd14, 32'h0000_0200);
        rd_chk("R5 code 4", 5'd13, 32'h0000_0810);
        rd_chk("R3 second push", 5'd12, 32'h0000_F810);

        // R4 two returns
        @(negedge clk); eret = 1; tick(12);
        rd_chk("R4 pop one", 5'd12, 32'h0000_F814);
        @(negedge clk); eret = 1; tick(12);
        rd_chk("R4 pop two", 5'd12, 32'h0000_F815);
        chk("R7 irq after return", {31'b0, irq_req}, 1);

        // R4 exception beats return; R9 other code keeps badaddr
        @(negedge clk); exc_valid = 1; eret = 1; exc_code = 12; pc_cur = 32'h300; pc_incr = 1; fault_addr = 32'h1234; tick(12);
        rd_chk("R4 exception priority", 5'd12, 32'h0000_F814);
        rd_chk("R9 badaddr held", 5'd8, 32'hDEAD_BEE0);
        rd_chk("R8 epc", 5'd14, 32'h0000_02FC);
        rd_chk("R5 code 12", 5'd13, 32'h0000_0830);

        // R11 exception beats status write
        @(negedge clk); exc_valid = 1; exc_code = 9; pc_cur = 32'h400; wr_en = 1; wr_num = 12; wr_data = 0; tick(12);
        rd_chk("R11 write lost to exception", 5'd12, 32'h0000_F810);
        rd_chk("R5 code 9", 5'd13, 32'h0000_0824);

        // R11 writes to 8 and 14 ignored
        @(negedge clk); wr_en = 1; wr_num = 8; wr_data = 32'h55; tick(8);
        rd_chk("R11 badaddr not writable", 5'd8, 32'hDEAD_BEE0);
        @(negedge clk); wr_en = 1; wr_num = 14; wr_data = 32'h66; tick(14);
        rd_chk("R11 epc not writable", 5'd14, 32'h0000_0400);

        // R6 arrival wins over clear, then plain clear
        @(negedge clk); wr_en = 1; wr_num = 13; wr_data = 32'h800; hw_irq = 5'b00001; tick(13);
        rd_chk("R6 arrival beats clear", 5'd13, 32'h0000_0824);
        @(negedge clk); wr_en = 1; wr_num = 13; wr_data = 32'h800; tick(13);
        rd_chk("R6 cleared", 5'd13, 32'h0000_0024);

        // R9 store address error
        @(negedge clk); exc_valid = 1; exc_code = 5; fault_addr = 32'h0000_0ABC; tick(8);
        rd_chk("R9 store addr error", 5'd8, 32'h0000_0ABC);
        rd_chk("R3 third push", 5'd12, 32'h0000_F800);

        // R10 unmapped numbers
        rd_chk("R10 unmapped 0", 5'd0, 0);
        rd_chk("R10 unmapped 31", 5'd31, 0);
        chk("R2 entry again", entry_addr, 32'h8000_0080);

        // random traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [4:0] sels [5] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3};
            logic [3:0] codes [9] = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
            @(negedge clk);
            exc_valid  = ($urandom % 8) == 0;
            exc_code   = codes[$urandom % 9];
            pc_cur     = $urandom;
            pc_incr    = $urandom % 2;
            fault_addr = $urandom;
            hw_irq     = 5'($urandom) & 5'($urandom) & 5'($urandom);
            eret       = ($urandom % 6) == 0;
            wr_en      = ($urandom % 5) == 0;
            wr_num     = sels[$urandom % 5];
            wr_data    = $urandom;
            tick(sels[k % 5]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule